// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and decides which request the core must service next. It gathers a reset request and a set of interrupt lines, latches each interrupt line into a pending flag, and masks the flags with a per-source enable bit, a global enable flag and a program-counter region lock. A fixed priority order picks the winner: the reset request first, then interrupt 0, then interrupt 1, and so on. The block presents the winner as a registered request with a vector address for the core to jump to.

The core takes a presented request by raising acknowledge while the request is shown. Acceptance clears the winner's pending flag and the global enable in the same clock edge, so no further interrupt is presented until the core returns. A return strobe sets the global enable again. Software can also set the global enable inside a handler to allow nesting. A vector-select bit moves the interrupt table from address zero to the boot region base. A static configuration input moves the reset vector in the same way.

Top module: `irqc_top`

## Requirements
- R1: Interrupt k is presented only if its enable bit and the global enable were both 1 in the cycle before it shows on `req_o`. Pending flags whose source is disabled or that are blocked by a clear global enable are held and not lost.
- R2: Slot 0 belongs to the reset request and slot k+1 to interrupt k. Among the eligible slots the lowest-numbered one is presented on `slot_o`.
- R3: The reset request is presented in slot 0 regardless of the global enable, the enable bits and the region lock. Its vector is 0, or `BOOT_BASE` when `boot_rst_cfg_i` is 1.
- R4: An accept (`ack_i` high while `req_o` is high) clears the global enable and the pending flag of the presented slot. `req_o` is then low in the next cycle.
- R5: If software writes 1 to the global enable while a handler runs, a pending enabled source is presented one cycle later, which preempts the handler.
- R6: `reti_i` sets the global enable to 1, unless an accept happens in the same cycle, in which case the global enable ends up 0.
- R7: `vec_o` = base + slot × `VEC_SPACING` (2 by default). For interrupt slots the base is 0 when the vector-select bit is 0 and `BOOT_BASE` when it is 1.
- R8: When `lock_cfg_i` is 1 and the program counter region differs from the interrupt table region, interrupts are suppressed but stay pending. The program counter is in the boot region when `pc_i` ≥ `BOOT_BASE`; the table is in the boot region when the vector-select bit is 1.
- R9: A pending flag is set in any cycle its input is high and stays set until that slot is accepted.
- R10: Outputs are registered. A pending flag set at clock edge n can show on `req_o` only after edge n+1.
- R11: After reset all enables, the global enable, the vector-select bit and all pending flags are 0, and `req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | N_IRQ | Interrupt request lines, bit k = interrupt k |
| rst_req_i | input | 1 | Reset request, slot 0 |
| en_we_i | input | 1 | Write strobe for the enable bits |
| en_d_i | input | N_IRQ | New enable bits |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_d_i | input | 1 | New global enable value |
| ivsel_we_i | input | 1 | Write strobe for the vector-select bit |
| ivsel_d_i | input | 1 | New vector-select value |
| boot_rst_cfg_i | input | 1 | Static: reset vector at the boot base |
| lock_cfg_i | input | 1 | Static: enable the program counter region lock |
| pc_i | input | ADDR_W | Current program counter |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_i | input | 1 | Core takes the presented request |
| req_o | output | 1 | A request is presented |
| vec_o | output | ADDR_W | Vector address of the presented slot |
| slot_o | output | SLOT_W | Presented slot number |
| gie_o | output | 1 | Global enable flag |
| pend_o | output | N_IRQ | Pending flags |

## Verification
On every cycle the assertions check that an accept clears the global enable and drops the request, that a return strobe without an accept restores the enable, that at most one pending flag clears per cycle, that a presented interrupt had the global enable set, that a reset request is always presented in slot 0, and that the arbiter never passes over a lower eligible slot. The bench scenarios show what a single cycle cannot: the full drain order for every combination of six sources with both table bases, vector arithmetic, the one-cycle registered latency, nesting after a software write to the global enable, and region-lock suppression while the pending flags are kept.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    BASE_LOW  = 1'b0,
    BASE_BOOT = 1'b1
  } base_sel_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/irqc_state.sv
module irqc_state #(
  parameter int N_IRQ  = 6,
  parameter int SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              en_we_i,
  input  logic [N_IRQ-1:0]  en_d_i,
  input  logic              gie_we_i,
  input  logic              gie_d_i,
  input  logic              ivsel_we_i,
  input  logic              ivsel_d_i,
  input  logic              reti_i,
  input  logic              accept_i,
  input  logic [SLOT_W-1:0] accept_slot_i,
  output logic [N_IRQ-1:0]  pend_q,
  output logic [N_IRQ-1:0]  en_q,
  output logic              gie_q,
  output logic              ivsel_q
);
  logic [N_IRQ-1:0] pend_n, en_n, clr_vec;
  logic             gie_n, ivsel_n;

  // Per-source clear decode: slot k+1 belongs to interrupt k.
  for (genvar k = 0; k < N_IRQ; k++) begin : g_clr
    assign clr_vec[k] = accept_i && (accept_slot_i == SLOT_W'(k + 1));
  end

  always_comb begin
    // a new request in the clear cycle is kept
    pend_n  = (pend_q & ~clr_vec) | irq_i;
    en_n    = en_we_i ? en_d_i : en_q;
    ivsel_n = ivsel_we_i ? ivsel_d_i : ivsel_q;
    // accept beats return, return beats software write
    if (accept_i)      gie_n = 1'b0;
    else if (reti_i)   gie_n = 1'b1;
    else if (gie_we_i) gie_n = gie_d_i;
    else               gie_n = gie_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      en_q    <= '0;
      gie_q   <= 1'b0;
      ivsel_q <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      en_q    <= en_n;
      gie_q   <= gie_n;
      ivsel_q <= ivsel_n;
    end
  end

  p_accept_clears_gie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !gie_q);

  p_reti_sets_gie_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !accept_i) |=> gie_q);

  p_single_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($past(pend_q) & ~pend_q) == '0);

  p_clear_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> $countones($past(pend_q) & ~pend_q) <= 1);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N_CAND = 7,
  parameter int SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CAND-1:0] cand_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] idx_o
);
  logic [N_CAND-1:0] below;

  // Scan from the top so the lowest set index is assigned last.
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N_CAND - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        valid_o = 1'b1;
        idx_o   = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_CAND; i++) below[i] = (SLOT_W'(i) < idx_o);
  end

  p_lowest_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cand_i[idx_o] && ((cand_i & below) == '0)));

  p_valid_iff_any_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i != '0) |-> valid_o);
endmodule

// File: rtl/irqc_vecgen.sv
module irqc_vecgen
  import irqc_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          SLOT_W      = 3,
  parameter int          VEC_SPACING = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hE00
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              ivsel_i,
  input  logic              boot_rst_cfg_i,
  output logic [ADDR_W-1:0] vec_o
);
  localparam bit SPACING_POW2 = (VEC_SPACING & (VEC_SPACING - 1)) == 0;
  localparam int SHIFT        = $clog2(VEC_SPACING);

  base_sel_e         sel;
  logic [ADDR_W-1:0] base, offset;

  always_comb begin
    if (slot_i == '0) sel = boot_rst_cfg_i ? BASE_BOOT : BASE_LOW;
    else              sel = ivsel_i ? BASE_BOOT : BASE_LOW;
    base = (sel == BASE_BOOT) ? BOOT_BASE : '0;
  end

  if (SPACING_POW2) begin : g_shift
    assign offset = ADDR_W'(slot_i) << SHIFT;
  end else begin : g_mul
    assign offset = ADDR_W'(slot_i) * ADDR_W'(VEC_SPACING);
  end

  assign vec_o = base + offset;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int          N_IRQ       = 6,
  parameter int          ADDR_W      = 12,
  parameter int          VEC_SPACING = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hE00,
  localparam int         N_CAND      = N_IRQ + 1,
  localparam int         SLOT_W      = $clog2(N_CAND)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              rst_req_i,
  input  logic              en_we_i,
  input  logic [N_IRQ-1:0]  en_d_i,
  input  logic              gie_we_i,
  input  logic              gie_d_i,
  input  logic              ivsel_we_i,
  input  logic              ivsel_d_i,
  input  logic              boot_rst_cfg_i,
  input  logic              lock_cfg_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              reti_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              gie_o,
  output logic [N_IRQ-1:0]  pend_o
);
  logic              rst_n;
  logic [N_IRQ-1:0]  pend_q, en_q;
  logic              gie_q, ivsel_q;
  logic              accept, pc_in_boot, locked;
  logic [N_CAND-1:0] cand;
  logic              win_valid;
  logic [SLOT_W-1:0] win_idx;
  logic [ADDR_W-1:0] win_vec;
  logic              req_q, req_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [ADDR_W-1:0] vec_q, vec_n;
  logic              out_en;

  irqc_rst_sync u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n)
  );

  assign accept = ack_i && req_q;

  irqc_state #(.N_IRQ(N_IRQ), .SLOT_W(SLOT_W)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .irq_i        (irq_i),
    .en_we_i      (en_we_i),
    .en_d_i       (en_d_i),
    .gie_we_i     (gie_we_i),
    .gie_d_i      (gie_d_i),
    .ivsel_we_i   (ivsel_we_i),
    .ivsel_d_i    (ivsel_d_i),
    .reti_i       (reti_i),
    .accept_i     (accept),
    .accept_slot_i(slot_q),
    .pend_q       (pend_q),
    .en_q         (en_q),
    .gie_q        (gie_q),
    .ivsel_q      (ivsel_q)
  );

  // Region lock: suppress when code runs outside the table's region.
  assign pc_in_boot = (pc_i >= BOOT_BASE);
  assign locked     = lock_cfg_i && (pc_in_boot != ivsel_q);

  assign cand[0] = rst_req_i;
  for (genvar k = 0; k < N_IRQ; k++) begin : g_cand
    assign cand[k+1] = pend_q[k] && en_q[k] && gie_q && !locked;
  end

  irqc_arbiter #(.N_CAND(N_CAND), .SLOT_W(SLOT_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .cand_i (cand),
    .valid_o(win_valid),
    .idx_o  (win_idx)
  );

  irqc_vecgen #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
    .VEC_SPACING(VEC_SPACING), .BOOT_BASE(BOOT_BASE)
  ) u_vec (
    .slot_i        (win_idx),
    .ivsel_i       (ivsel_q),
    .boot_rst_cfg_i(boot_rst_cfg_i),
    .vec_o         (win_vec)
  );

  always_comb begin
    req_n  = win_valid && !accept;
    out_en = win_valid;
    slot_n = win_idx;
    vec_n  = win_vec;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      slot_q <= '0;
      vec_q  <= '0;
    end else begin
      req_q <= req_n;
      if (out_en) begin
        slot_q <= slot_n;
        vec_q  <= vec_n;
      end
    end
  end

  assign req_o  = req_q;
  assign vec_o  = vec_q;
  assign slot_o = slot_q;
  assign gie_o  = gie_q;
  assign pend_o = pend_q;

  p_irq_needs_gie_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_q && slot_q != '0) |-> $past(gie_q));

  p_reset_first_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rst_req_i && !accept) |=> (req_q && slot_q == '0));

  p_accept_drops_req_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    accept |=> !req_q);
endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ  = 6;
  localparam int ADDR_W = 12;
  localparam int SP     = 2;
  localparam int BOOT   = 12'hE00;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_IRQ-1:0] irq, en_d;
  logic rst_req, en_we, gie_we, gie_d, ivsel_we, ivsel_d, boot_rst, lock, reti, ack;
  logic [ADDR_W-1:0] pc;
  logic req;
  logic [ADDR_W-1:0] vec;
  logic [2:0] slot;
  logic gie;
  logic [N_IRQ-1:0] pend;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irqc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .rst_req_i(rst_req),
    .en_we_i(en_we), .en_d_i(en_d), .gie_we_i(gie_we), .gie_d_i(gie_d),
    .ivsel_we_i(ivsel_we), .ivsel_d_i(ivsel_d), .boot_rst_cfg_i(boot_rst),
    .lock_cfg_i(lock), .pc_i(pc), .reti_i(reti), .ack_i(ack),
    .req_o(req), .vec_o(vec), .slot_o(slot), .gie_o(gie), .pend_o(pend)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(int m);
    for (int i = 0; i < N_IRQ; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  task automatic setup(int en, bit g, bit iv);
    en_we = 1; en_d = N_IRQ'(en); gie_we = 1; gie_d = g; ivsel_we = 1; ivsel_d = iv;
    step();
    en_we = 0; gie_we = 0; ivsel_we = 0;
  endtask

  task automatic pulse(int m);
    irq = N_IRQ'(m);
    step();
    irq = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; irq = '0; en_d = '0; rst_req = 0; en_we = 0; gie_we = 0; gie_d = 0;
    ivsel_we = 0; ivsel_d = 0; boot_rst = 0; lock = 0; reti = 0; ack = 0; pc = '0;
    do_reset();
    // R11 reset state
    chk("R11", "req", int'(req), 0);
    chk("R11", "gie", int'(gie), 0);
    chk("R11", "pend", int'(pend), 0);

    // R2 R4 R7 R9 R10: sweep every source combination, drain in priority order
    for (int m = 0; m < (1 << N_IRQ); m++) begin
      int rem;
      bit iv;
      iv = (m % 3 == 0);
      do_reset();
      setup((1 << N_IRQ) - 1, 1'b1, iv);
      pulse(m);
      chk("R10", "req before latency", int'(req), 0);
      chk("R9", "pend latched", int'(pend), m);
      step();
      rem = m;
      while (rem != 0) begin
        int w;
        w = lowest(rem);
        chk("R2", "req", int'(req), 1);
        chk("R2", "slot", int'(slot), w + 1);
        chk("R7", "vec", int'(vec), ((iv ? BOOT : 0) + (w + 1) * SP) % (1 << ADDR_W));
        ack = 1;
        step();
        ack = 0;
        rem = rem & ~(1 << w);
        chk("R4", "req after accept", int'(req), 0);
        chk("R4", "gie after accept", int'(gie), 0);
        chk("R4", "pend after accept", int'(pend), rem);
        reti = 1;
        step();
        reti = 0;
        chk("R6", "gie after reti", int'(gie), 1);
        step();
      end
      chk("R2", "idle after drain", int'(req), 0);
    end

    // R1: only enabled sources, and global enable gating
    do_reset();
    setup(6'b101010, 1'b1, 1'b0);
    pulse(6'b111111);
    step();
    chk("R1", "slot with partial enables", int'(slot), 2);
    chk("R1", "req partial", int'(req), 1);
    do_reset();
    setup(6'b111111, 1'b0, 1'b0);
    pulse(6'b000001);
    step(); step();
    chk("R1", "req with gie clear", int'(req), 0);
    chk("R1", "pend kept with gie clear", int'(pend), 1);

    // R3: reset request ignores gie and enables
    do_reset();
    rst_req = 1;
    step(); step();
    chk("R3", "req", int'(req), 1);
    chk("R3", "slot", int'(slot), 0);
    chk("R3", "vec low", int'(vec), 0);
    boot_rst = 1;
    step(); step();
    chk("R3", "vec boot", int'(vec), BOOT);
    rst_req = 0; boot_rst = 0;
    step(); step();
    chk("R3", "req released", int'(req), 0);

    // R5: nesting after software sets gie
    do_reset();
    setup(6'b111111, 1'b1, 1'b0);
    pulse(6'b000100);
    step();
    chk("R5", "first slot", int'(slot), 3);
    ack = 1;
    step();
    ack = 0;
    pulse(6'b000001);
    step();
    chk("R5", "blocked inside handler", int'(req), 0);
    gie_we = 1; gie_d = 1;
    step();
    gie_we = 0;
    chk("R5", "gie written", int'(gie), 1);
    step();
    chk("R5", "preempt req", int'(req), 1);
    chk("R5", "preempt slot", int'(slot), 1);

    // R6: accept and return in the same cycle
    ack = 1; reti = 1;
    step();
    ack = 0; reti = 0;
    chk("R6", "accept beats reti", int'(gie), 0);

    // R8: region lock
    do_reset();
    lock = 1; pc = ADDR_W'(BOOT);
    setup(6'b111111, 1'b1, 1'b0);
    pulse(6'b001000);
    step(); step();
    chk("R8", "suppressed in boot", int'(req), 0);
    chk("R8", "pend kept", int'(pend), 8);
    pc = '0;
    step();
    chk("R8", "released low", int'(req), 1);
    chk("R8", "slot", int'(slot), 4);
    ivsel_we = 1; ivsel_d = 1;
    step();
    ivsel_we = 0;
    step();
    chk("R8", "suppressed low with boot table", int'(req), 0);
    pc = ADDR_W'(BOOT + 4);
    step(); step();
    chk("R8", "released boot", int'(req), 1);
    chk("R7", "boot vec", int'(vec), BOOT + 4 * SP);
    lock = 0;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule